// File: doc/BRIEF.md
# Saturating Adder with Unsigned and Signed Modes

This block adds two operands of a parameterised width. When the exact sum fits the selected number format, it returns the ordinary sum. When the exact sum falls outside that format, it does not wrap around. It returns the nearest value the format can hold. The result is typical of signal-processing datapaths, where a clamped value does much less harm than a wrapped one.

A single mode input sets how the operand bits are read. In one setting they are plain unsigned binary; in the other they are two's-complement. The same carry chain serves both settings. A small detector turns the mode, the operand sign bits and the carries into an overflow decision and a clamp constant. A two-way multiplexer then chooses between the adder's sum and that constant, using the overflow decision as its select.

By default the result and a clamp flag are registered, so they appear one clock after the operands are sampled. A parameter can remove this register stage to give a purely combinational path.

Top module: `sat_adder`

## Requirements
- R1: With `is_signed` = 0 (unsigned mode), when a + b ≤ 2^WIDTH − 1, `sum_o` equals a + b and `sat_o` is 0.
- R2: With `is_signed` = 0, when a + b ≥ 2^WIDTH (carry out of the top bit), `sum_o` is all ones and `sat_o` is 1.
- R3: With `is_signed` = 1 (two's-complement mode), when the signed sum lies in [−2^(WIDTH−1), 2^(WIDTH−1) − 1], `sum_o` equals the signed sum and `sat_o` is 0.
- R4: With `is_signed` = 1, when both operands are non-negative and the signed sum exceeds 2^(WIDTH−1) − 1, `sum_o` is 0 followed by all ones (e.g. 120 + 26 gives 127 at WIDTH = 8), and `sat_o` is 1.
- R5: With `is_signed` = 1, when both operands are negative and the signed sum is below −2^(WIDTH−1), `sum_o` is 1 followed by all zeros, and `sat_o` is 1.
- R6: `sat_o` is 1 exactly when `sum_o` differs from the wrapped sum (a + b) mod 2^WIDTH.
- R7: With OUT_REG = 1, `sum_o` and `sat_o` show the result for the operands and mode sampled at the previous rising clock edge. A synchronous active-high `rst` clears both outputs to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| is_signed | input | 1 | 0 = unsigned, 1 = two's-complement |
| sum_o | output | WIDTH | Clamped sum |
| sat_o | output | 1 | 1 when the result was clamped |

## Verification
On every cycle the assertions check several relations. The multiplexer output must hold the right clamp constant whenever each kind of overflow condition is present. The flag must agree with whether the chosen value differs from the raw sum. In signed mode, the sign-based overflow test must match the carry-in/carry-out disagreement at the top bit. The registered outputs must follow the combinational result by one cycle, and reset must clear them. Only the bench's scenarios can show that the values are numerically right against an exact wide-integer sum. The scenarios cover operands exactly on the overflow threshold and one past it, extreme pairs such as minimum plus minimum, and random operands in both modes.

// File: rtl/sat_adder_pkg.sv
package sat_adder_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } add_mode_e;
endpackage

// File: rtl/sat_raw_add.sv
module sat_raw_add #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             c_msb,
  output logic             c_out
);
  logic [WIDTH:0] carry;

  // ripple chain: parity for sum, majority for carry
  always_comb begin
    carry[0] = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      sum[i]     = a[i] ^ b[i] ^ carry[i];
      carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end
  end

  assign c_msb = carry[WIDTH-1];
  assign c_out = carry[WIDTH];
endmodule

// File: rtl/sat_ovf_detect.sv
module sat_ovf_detect
  import sat_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  add_mode_e        mode,
  input  logic             a_msb,
  input  logic             b_msb,
  input  logic             sum_msb,
  input  logic             c_out,
  output logic             ovf,
  output logic [WIDTH-1:0] sat_val
);
  localparam logic [WIDTH-1:0] U_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] S_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] S_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    if (mode == MODE_SGN) begin
      ovf     = (a_msb == b_msb) && (sum_msb != a_msb);
      sat_val = a_msb ? S_MIN : S_MAX;
    end else begin
      ovf     = c_out;
      sat_val = U_MAX;
    end
  end
endmodule

// File: rtl/sat_sel_mux.sv
module sat_sel_mux #(
  parameter int WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] raw,
  input  logic [WIDTH-1:0] clamp,
  output logic [WIDTH-1:0] y
);
  assign y = sel ? clamp : raw;
endmodule

// File: rtl/sat_adder.sv
module sat_adder
  import sat_adder_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             is_signed,
  output logic [WIDTH-1:0] sum_o,
  output logic             sat_o
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] U_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] S_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] S_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  add_mode_e        mode;
  logic [WIDTH-1:0] raw_sum;
  logic             c_msb;
  logic             c_out;
  logic             ovf;
  logic [WIDTH-1:0] clamp_val;
  logic [WIDTH-1:0] mux_out;

  assign mode = add_mode_e'(is_signed);

  sat_raw_add #(.WIDTH(WIDTH)) u_add (
    .a     (op_a),
    .b     (op_b),
    .sum   (raw_sum),
    .c_msb (c_msb),
    .c_out (c_out)
  );

  sat_ovf_detect #(.WIDTH(WIDTH)) u_det (
    .mode    (mode),
    .a_msb   (op_a[MSB]),
    .b_msb   (op_b[MSB]),
    .sum_msb (raw_sum[MSB]),
    .c_out   (c_out),
    .ovf     (ovf),
    .sat_val (clamp_val)
  );

  sat_sel_mux #(.WIDTH(WIDTH)) u_mux (
    .sel   (ovf),
    .raw   (raw_sum),
    .clamp (clamp_val),
    .y     (mux_out)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          sum_o <= '0;
          sat_o <= 1'b0;
        end else begin
          sum_o <= mux_out;
          sat_o <= ovf;
        end
      end

      // R7: outputs follow the combinational result one cycle later
      p_pipe_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_o == $past(mux_out)) && (sat_o == $past(mux_out != raw_sum)));
      // R7: reset clears outputs
      p_reset_r7: assert property (@(posedge clk)
        rst |=> (sum_o == '0) && !sat_o);
    end else begin : g_comb
      assign sum_o = mux_out;
      assign sat_o = ovf;
    end
  endgenerate

  // R2: unsigned carry out forces all ones
  p_uns_clamp_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UNS && c_out) |-> (mux_out == U_MAX));
  // R4: positive signed overflow clamps to the top value
  p_pos_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SGN && !op_a[MSB] && !op_b[MSB] && raw_sum[MSB]) |-> (mux_out == S_MAX));
  // R5: negative signed overflow clamps to the bottom value
  p_neg_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SGN && op_a[MSB] && op_b[MSB] && !raw_sum[MSB]) |-> (mux_out == S_MIN));
  // R3: sign test agrees with carry disagreement at the top bit
  p_sgn_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SGN) |-> (ovf == (c_msb ^ c_out)));
  // R6: flag marks exactly a change from the wrapped sum
  p_flag_r6: assert property (@(posedge clk) disable iff (rst)
    ovf == (mux_out != raw_sum));
  // R1: no unsigned carry leaves the raw sum untouched
  p_uns_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UNS && !c_out) |-> (mux_out == raw_sum));
endmodule

// File: tb/sim_sat_adder.sv
module sim_sat_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         is_signed = 1'b0;
  logic [W-1:0] sum_o;
  logic         sat_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  sat_adder #(.WIDTH(W), .OUT_REG(1'b1)) u0 (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (is_signed),
    .sum_o     (sum_o),
    .sat_o     (sat_o)
  );

  function automatic void ref_calc(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic sm, output logic [W-1:0] r,
                                   output logic f);
    longint ex, lo, hi, cl;
    if (sm) begin
      ex = longint'($signed(a)) + longint'($signed(b));
      hi = (64'sd1 <<< (W-1)) - 1;
      lo = -(64'sd1 <<< (W-1));
    end else begin
      ex = longint'({1'b0, a}) + longint'({1'b0, b});
      hi = (64'sd1 <<< W) - 1;
      lo = 0;
    end
    cl = (ex > hi) ? hi : ((ex < lo) ? lo : ex);
    r  = cl[W-1:0];
    f  = (cl != ex);
  endfunction

  function automatic string req_of(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic sm);
    logic [W-1:0] r;
    logic f;
    ref_calc(a, b, sm, r, f);
    if (!sm) return f ? "R2" : "R1";
    if (!f) return "R3";
    return a[W-1] ? "R5" : "R4";
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm);
    logic [W-1:0] er;
    logic ef;
    string rq;
    ref_calc(a, b, sm, er, ef);
    rq = req_of(a, b, sm);
    @(negedge clk);
    op_a = a; op_b = b; is_signed = sm;
    @(posedge clk);
    #1;
    n_checks++;
    if (sum_o !== er) begin
      n_fails++;
      $display("FAIL %s sum: a=%0d b=%0d mode=%0d actual=%0d expected=%0d",
               rq, a, b, sm, sum_o, er);
    end
    n_checks++;
    if (sat_o !== ef) begin
      n_fails++;
      $display("FAIL R6 flag: a=%0d b=%0d mode=%0d actual=%0d expected=%0d",
               a, b, sm, sat_o, ef);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    op_a = 8'd55; op_b = 8'd99;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    n_checks++;
    if (sum_o !== '0 || sat_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R7 reset: actual=%0d/%0d expected=0/0", sum_o, sat_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2 unsigned directed
    apply(8'd0,   8'd0,   1'b0);
    apply(8'd254, 8'd1,   1'b0);
    apply(8'd255, 8'd0,   1'b0);
    apply(8'd255, 8'd1,   1'b0);
    apply(8'd255, 8'd255, 1'b0);
    apply(8'd128, 8'd127, 1'b0);
    apply(8'd128, 8'd128, 1'b0);
    // R3 / R4 / R5 signed directed
    apply(8'd120, 8'd26,  1'b1);
    apply(8'd127, 8'd0,   1'b1);
    apply(8'd127, 8'd1,   1'b1);
    apply(8'd100, 8'd27,  1'b1);
    apply(8'h80,  8'h00,  1'b1);
    apply(8'h80,  8'hFF,  1'b1);
    apply(8'hC0,  8'hC0,  1'b1);
    apply(8'hC0,  8'hBF,  1'b1);
    apply(8'h80,  8'h80,  1'b1);
    apply(8'h7F,  8'h80,  1'b1);
    apply(8'd255, 8'd1,   1'b1);

    // random in both modes
    for (int i = 0; i < 3000; i++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom));
    end

    // R7: reset mid-run clears outputs
    apply(8'd127, 8'd1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    n_checks++;
    if (sum_o !== '0 || sat_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R7 mid reset: actual=%0d/%0d expected=0/0", sum_o, sat_o);
    end
    @(negedge clk);
    rst = 1'b0;
    apply(8'd10, 8'd20, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule